// File: doc/BRIEF.md
# Dual Command/Receive FIFO with Watermark Interrupts

This block sits between a register bank and a serial bus engine. Software pushes command words into a transmit queue, and the engine pops them one at a time. Bytes that the engine receives are pushed into a receive queue, which software drains. Both queues hold 64 entries. Each queue records misuse in sticky flags: a pop from an empty queue is a read error, and a push into a full queue is a write error.

A single control write can flush either queue and set two watermarks. The receive watermark raises an almost-full condition and the transmit watermark raises an almost-empty condition. A five-source interrupt unit collects the following into a raw status word:
- the two watermark conditions;
- a combined FIFO-error condition;
- a transfer-complete pulse from the engine;
- a transfer-error pulse from the engine.

An enable mask selects which raw bits reach the masked status and the interrupt line. Raw bits are acknowledged by writing ones.

Top module: `dual_fifo_irq`

## Requirements
- R1: During reset, `status_word` reads 0x008 (only receive-empty set), and `irq_raw`, `irq_stat` and `irq_line` are all zero.
- R2: Each queue holds exactly 64 entries and delivers them in push order. `status_word` bit 11 is set while the transmit queue holds 64 entries, and `eng_cmd_valid` is high while the transmit queue is not empty.
- R3: A push into a full queue is dropped and sets its sticky write-error flag: bit 1 for receive, bit 7 for transmit. The flag stays set until that queue is flushed.
- R4: A pop from an empty queue leaves the read-data output at its previous value and sets its sticky read-error flag: bit 0 for receive, bit 6 for transmit. `status_word` bit 3 is set while the receive queue is empty.
- R5: A control write with bit 0 set flushes the receive queue, and one with bit 1 set flushes the transmit queue. A flush empties that queue and clears its two error flags. The flush bits are self-clearing: `ctrl_rdata` reads them as 0, and it reads back the watermark fields.
- R6: Raw bit 3 (receive almost-full) is set when the receive occupancy is at or above control field [7:2]. Raw bit 4 (transmit almost-empty) is set when the transmit occupancy is at or below control field [13:8].
- R7: Raw bit 2 (FIFO error) is set while any of the four error flags is set.
- R8: An `eng_done` pulse sets raw bit 0 and an `eng_err` pulse sets raw bit 1. These bits stay set until acknowledged. An event in the same cycle as its acknowledge wins.
- R9: `irq_stat` equals `irq_raw` ANDed with the enable mask (a 1 enables a source), and `irq_line` is the OR of `irq_stat`.
- R10: Writing ones to the acknowledge register clears those raw bits at the next edge. A level source whose condition still holds sets its bit again one cycle later.
- R11: Read data (`reg_rx_data`, `eng_cmd_data`) is registered and shows the popped entry in the cycle after the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_cmd_push | input | 1 | Push a command word into the transmit queue |
| reg_cmd_data | input | 11 | Command word to push |
| reg_rx_pop | input | 1 | Pop a byte from the receive queue |
| reg_rx_data | output | 8 | Last byte popped from the receive queue |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 14 | Control word: [0] receive flush, [1] transmit flush, [7:2] receive watermark, [13:8] transmit watermark |
| ctrl_rdata | output | 14 | Control readback, flush bits read 0 |
| status_word | output | 12 | Queue status flags |
| irq_mask_we | input | 1 | Enable-mask write strobe |
| irq_mask_wdata | input | 5 | New enable mask |
| irq_clr_we | input | 1 | Acknowledge write strobe |
| irq_clr_wdata | input | 5 | Raw bits to acknowledge |
| irq_raw | output | 5 | Raw interrupt status |
| irq_stat | output | 5 | Masked interrupt status |
| irq_line | output | 1 | Interrupt request |
| eng_cmd_pop | input | 1 | Engine pops a command word |
| eng_cmd_data | output | 11 | Last command word popped |
| eng_cmd_valid | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine pushes a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_full | output | 1 | Receive queue full |
| eng_done | input | 1 | Transfer-complete event pulse |
| eng_err | input | 1 | Transfer-error event pulse |

## Verification
A wrong pointer or count shows at the read-data ports within one pop: an entry arrives out of order, or the full/empty flags appear after the wrong number of pushes. A lost sticky flag shows in `status_word` in the cycle after the offending access. The raw interrupt bits that follow it show the error one edge later. A wrong watermark compare or acknowledge priority shows in `irq_raw` two edges after the acknowledge, which is when a level source that still holds must reappear.

// File: rtl/dfq_pkg.sv
package dfq_pkg;
    // status word bit positions (decoded by software)
    localparam int ST_W        = 12;
    localparam int ST_RX_RERR  = 0;
    localparam int ST_RX_WERR  = 1;
    localparam int ST_RX_EMPTY = 3;
    localparam int ST_TX_RERR  = 6;
    localparam int ST_TX_WERR  = 7;
    localparam int ST_TX_FULL  = 11;

    // interrupt source positions
    localparam int IQ_N    = 5;
    localparam int IQ_DONE = 0;
    localparam int IQ_XERR = 1;
    localparam int IQ_FERR = 2;
    localparam int IQ_RXAF = 3;
    localparam int IQ_TXAE = 4;

    typedef struct packed {
        logic rerr;
        logic werr;
        logic empty;
        logic full;
    } fifo_flags_t;
endpackage

// File: rtl/dfq_fifo.sv
module dfq_fifo
    import dfq_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count,
    output fifo_flags_t      flags
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          rerr, werr;
    logic          full, empty, do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            rdata <= '0;
            rerr  <= 1'b0;
            werr  <= 1'b0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            rerr  <= 1'b0;
            werr  <= 1'b0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (push && full) werr <= 1'b1;
            if (do_pop) begin
                rdata <= mem[rp];
                rp    <= nxt(rp);
            end
            if (pop && empty) rerr <= 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assign flags = '{rerr: rerr, werr: werr, empty: empty, full: full};

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count)) && werr); // R3
    AST_WERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (werr && !flush) |=> werr); // R3
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !flush) |=> $stable(rdata) && rerr); // R4
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && !rerr && !werr); // R5
endmodule

// File: rtl/dfq_irq.sv
module dfq_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] lvl,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    input  logic         clr_we,
    input  logic [N-1:0] clr_wdata,
    output logic [N-1:0] raw,
    output logic [N-1:0] stat,
    output logic         line
);
    logic [N-1:0] mask_q;
    logic [N-1:0] clr;

    assign clr = clr_we ? clr_wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw    <= '0;
            mask_q <= '0;
        end else begin
            raw <= (raw & ~clr) | evt | (lvl & ~clr);
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign stat = raw & mask_q;
    assign line = |stat;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((raw & $past(evt)) == $past(evt))); // R8
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw & $past(clr_wdata & ~evt)) == '0)); // R10
    AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((raw & $past(raw)) == $past(raw))); // R8
endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
    import dfq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CMD_W = 11,
    parameter int RX_W  = 8,
    localparam int THR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int CTRL_W = 2 + 2 * THR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_cmd_push,
    input  logic [CMD_W-1:0]  reg_cmd_data,
    input  logic              reg_rx_pop,
    output logic [RX_W-1:0]   reg_rx_data,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [ST_W-1:0]   status_word,
    input  logic              irq_mask_we,
    input  logic [IQ_N-1:0]   irq_mask_wdata,
    input  logic              irq_clr_we,
    input  logic [IQ_N-1:0]   irq_clr_wdata,
    output logic [IQ_N-1:0]   irq_raw,
    output logic [IQ_N-1:0]   irq_stat,
    output logic              irq_line,
    input  logic              eng_cmd_pop,
    output logic [CMD_W-1:0]  eng_cmd_data,
    output logic              eng_cmd_valid,
    input  logic              eng_rx_push,
    input  logic [RX_W-1:0]   eng_rx_data,
    output logic              eng_rx_full,
    input  logic              eng_done,
    input  logic              eng_err
);
    logic [THR_W-1:0] rx_thr, tx_thr;
    logic             rx_flush, tx_flush;
    logic [CNT_W-1:0] rx_cnt, tx_cnt;
    fifo_flags_t      rx_fl, tx_fl;
    logic [IQ_N-1:0]  evt, lvl;

    // control: watermarks stored, flush bits act for one cycle only
    assign rx_flush = ctrl_we && ctrl_wdata[0];
    assign tx_flush = ctrl_we && ctrl_wdata[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_thr <= '0;
            tx_thr <= '0;
        end else if (ctrl_we) begin
            rx_thr <= ctrl_wdata[2 +: THR_W];
            tx_thr <= ctrl_wdata[2 + THR_W +: THR_W];
        end
    end

    assign ctrl_rdata = {tx_thr, rx_thr, 2'b00};

    dfq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(reg_cmd_push), .wdata(reg_cmd_data),
        .pop(eng_cmd_pop), .rdata(eng_cmd_data),
        .count(tx_cnt), .flags(tx_fl)
    );

    dfq_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(reg_rx_pop), .rdata(reg_rx_data),
        .count(rx_cnt), .flags(rx_fl)
    );

    assign eng_cmd_valid = !tx_fl.empty;
    assign eng_rx_full   = rx_fl.full;

    always_comb begin
        status_word              = '0;
        status_word[ST_RX_RERR]  = rx_fl.rerr;
        status_word[ST_RX_WERR]  = rx_fl.werr;
        status_word[ST_RX_EMPTY] = rx_fl.empty;
        status_word[ST_TX_RERR]  = tx_fl.rerr;
        status_word[ST_TX_WERR]  = tx_fl.werr;
        status_word[ST_TX_FULL]  = tx_fl.full;
    end

    always_comb begin
        evt          = '0;
        lvl          = '0;
        evt[IQ_DONE] = eng_done;
        evt[IQ_XERR] = eng_err;
        lvl[IQ_FERR] = rx_fl.rerr | rx_fl.werr | tx_fl.rerr | tx_fl.werr;
        lvl[IQ_RXAF] = (rx_cnt >= CNT_W'(rx_thr));
        lvl[IQ_TXAE] = (tx_cnt <= CNT_W'(tx_thr));
    end

    dfq_irq #(.N(IQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt), .lvl(lvl),
        .mask_we(irq_mask_we), .mask_wdata(irq_mask_wdata),
        .clr_we(irq_clr_we), .clr_wdata(irq_clr_wdata),
        .raw(irq_raw), .stat(irq_stat), .line(irq_line)
    );

    AST_RXAF_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_cnt >= CNT_W'(rx_thr)) && !(irq_clr_we && irq_clr_wdata[IQ_RXAF]))
        |=> irq_raw[IQ_RXAF]); // R6
    AST_TXAE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_cnt <= CNT_W'(tx_thr)) && !(irq_clr_we && irq_clr_wdata[IQ_TXAE]))
        |=> irq_raw[IQ_TXAE]); // R6
    AST_FERR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_word[ST_TX_WERR] || status_word[ST_RX_RERR])
         && !(irq_clr_we && irq_clr_wdata[IQ_FERR])) |=> irq_raw[IQ_FERR]); // R7
endmodule

// File: tb/tb_dual_fifo_irq.sv
module tb_dual_fifo_irq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_cmd_push, reg_rx_pop, ctrl_we, irq_mask_we, irq_clr_we;
    logic        eng_cmd_pop, eng_rx_push, eng_done, eng_err;
    logic [10:0] reg_cmd_data, eng_cmd_data;
    logic [7:0]  reg_rx_data, eng_rx_data;
    logic [13:0] ctrl_wdata, ctrl_rdata;
    logic [11:0] status_word;
    logic [4:0]  irq_mask_wdata, irq_clr_wdata, irq_raw, irq_stat;
    logic        irq_line, eng_cmd_valid, eng_rx_full;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dual_fifo_irq dut (
        .clk(clk), .rst_n(rst_n),
        .reg_cmd_push(reg_cmd_push), .reg_cmd_data(reg_cmd_data),
        .reg_rx_pop(reg_rx_pop), .reg_rx_data(reg_rx_data),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .status_word(status_word),
        .irq_mask_we(irq_mask_we), .irq_mask_wdata(irq_mask_wdata),
        .irq_clr_we(irq_clr_we), .irq_clr_wdata(irq_clr_wdata),
        .irq_raw(irq_raw), .irq_stat(irq_stat), .irq_line(irq_line),
        .eng_cmd_pop(eng_cmd_pop), .eng_cmd_data(eng_cmd_data),
        .eng_cmd_valid(eng_cmd_valid),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_rx_full(eng_rx_full),
        .eng_done(eng_done), .eng_err(eng_err)
    );

    // rows: rx watermark, tx watermark, entries pushed to both, expect rx-af, expect tx-ae
    localparam logic [20:0] VEC [8] = '{
        {6'd0,  6'd0,  7'd0,  1'b1, 1'b1},
        {6'd5,  6'd3,  7'd3,  1'b0, 1'b1},
        {6'd5,  6'd3,  7'd4,  1'b0, 1'b0},
        {6'd5,  6'd3,  7'd5,  1'b1, 1'b0},
        {6'd63, 6'd63, 7'd63, 1'b1, 1'b1},
        {6'd63, 6'd62, 7'd63, 1'b1, 1'b0},
        {6'd10, 6'd0,  7'd64, 1'b1, 1'b0},
        {6'd40, 6'd40, 7'd39, 1'b0, 1'b1}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [13:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v; tick(); ctrl_we = 1'b0;
    endtask

    task automatic wr_clr(input logic [4:0] v);
        irq_clr_we = 1'b1; irq_clr_wdata = v; tick(); irq_clr_we = 1'b0;
    endtask

    task automatic wr_mask(input logic [4:0] v);
        irq_mask_we = 1'b1; irq_mask_wdata = v; tick(); irq_mask_we = 1'b0;
    endtask

    task automatic push_cmd(input logic [10:0] v);
        reg_cmd_push = 1'b1; reg_cmd_data = v; tick(); reg_cmd_push = 1'b0;
    endtask

    task automatic pop_cmd();
        eng_cmd_pop = 1'b1; tick(); eng_cmd_pop = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] v);
        eng_rx_push = 1'b1; eng_rx_data = v; tick(); eng_rx_push = 1'b0;
    endtask

    task automatic pop_rx();
        reg_rx_pop = 1'b1; tick(); reg_rx_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {reg_cmd_push, reg_rx_pop, ctrl_we, irq_mask_we, irq_clr_we} = '0;
        {eng_cmd_pop, eng_rx_push, eng_done, eng_err} = '0;
        reg_cmd_data = '0; eng_rx_data = '0; ctrl_wdata = '0;
        irq_mask_wdata = '0; irq_clr_wdata = '0;
        repeat (3) tick();
        chk("R1", "status in reset", 32'(status_word), 32'h008);
        chk("R1", "raw in reset", 32'(irq_raw), 32'h0);
        chk("R1", "line in reset", {irq_stat, irq_line}, 32'h0);
        chk("R2", "cmd valid in reset", 32'(eng_cmd_valid), 32'h0);
        rst_n = 1'b1;
        tick();

        // watermark table, R6
        for (int i = 0; i < 8; i++) begin
            wr_ctrl({VEC[i][14:9], VEC[i][20:15], 2'b11});
            for (int k = 0; k < int'(VEC[i][8:2]); k++) begin
                reg_cmd_push = 1'b1; reg_cmd_data = 11'(k);
                eng_rx_push = 1'b1;  eng_rx_data = 8'(k);
                tick();
            end
            reg_cmd_push = 1'b0; eng_rx_push = 1'b0;
            wr_clr(5'b11000);
            tick();
            chk("R6", $sformatf("rx almost-full row %0d", i), 32'(irq_raw[3]), 32'(VEC[i][1]));
            chk("R6", $sformatf("tx almost-empty row %0d", i), 32'(irq_raw[4]), 32'(VEC[i][0]));
        end

        // transmit capacity, order, overflow and underflow
        wr_ctrl(14'b11);
        for (int i = 0; i < 64; i++) push_cmd(11'(i * 3 + 5));
        chk("R2", "tx full flag after 64", 32'(status_word[11]), 32'h1);
        chk("R2", "cmd valid when filled", 32'(eng_cmd_valid), 32'h1);
        push_cmd(11'h7FF);
        chk("R3", "tx write error", 32'(status_word[7]), 32'h1);
        for (int i = 0; i < 64; i++) begin
            pop_cmd();
            chk("R11", $sformatf("cmd entry %0d", i), 32'(eng_cmd_data), 32'(i * 3 + 5));
        end
        chk("R2", "cmd valid drained", 32'(eng_cmd_valid), 32'h0);
        chk("R4", "tx read error before underflow", 32'(status_word[6]), 32'h0);
        pop_cmd();
        chk("R4", "cmd data held on underflow", 32'(eng_cmd_data), 32'd194);
        chk("R4", "tx read error", 32'(status_word[6]), 32'h1);
        chk("R3", "tx write error sticky", 32'(status_word[7]), 32'h1);
        tick();
        chk("R7", "fifo error raw", 32'(irq_raw[2]), 32'h1);

        // flush transmit only, new watermarks
        wr_ctrl({6'd9, 6'd7, 2'b10});
        chk("R5", "tx errors cleared", 32'(status_word[7:6]), 32'h0);
        chk("R5", "ctrl readback", 32'(ctrl_rdata), 32'({6'd9, 6'd7, 2'b00}));
        wr_clr(5'b00100);
        tick();
        chk("R10", "fifo error stays clear", 32'(irq_raw[2]), 32'h0);

        // receive side
        push_rx(8'hA5);
        push_rx(8'h3C);
        chk("R4", "rx not empty", 32'(status_word[3]), 32'h0);
        pop_rx();
        chk("R11", "rx first byte", 32'(reg_rx_data), 32'hA5);
        pop_rx();
        chk("R11", "rx second byte", 32'(reg_rx_data), 32'h3C);
        pop_rx();
        chk("R4", "rx data held on underflow", 32'(reg_rx_data), 32'h3C);
        chk("R4", "rx read error and empty", {status_word[3], status_word[0]}, 32'h3);
        for (int i = 0; i < 64; i++) push_rx(8'(i));
        chk("R2", "rx full output", 32'(eng_rx_full), 32'h1);
        chk("R3", "rx no write error yet", 32'(status_word[1]), 32'h0);
        push_rx(8'hEE);
        chk("R3", "rx write error", 32'(status_word[1]), 32'h1);
        pop_rx();
        chk("R3", "rx dropped byte not stored", 32'(reg_rx_data), 32'h00);
        wr_ctrl({6'd9, 6'd7, 2'b01});
        chk("R5", "status after rx flush", 32'(status_word), 32'h008);

        // events, mask, acknowledge
        wr_clr(5'b11111);
        eng_done = 1'b1; tick(); eng_done = 1'b0;
        chk("R8", "done sets raw", 32'(irq_raw[0]), 32'h1);
        chk("R9", "masked off", {irq_stat, irq_line}, 32'h0);
        wr_mask(5'b00001);
        chk("R9", "done enabled", {irq_stat, irq_line}, 32'({5'b00001, 1'b1}));
        irq_clr_we = 1'b1; irq_clr_wdata = 5'b00001; eng_done = 1'b1;
        tick();
        irq_clr_we = 1'b0; eng_done = 1'b0;
        chk("R8", "event wins over ack", 32'(irq_raw[0]), 32'h1);
        wr_clr(5'b00001);
        chk("R10", "done acknowledged", {irq_raw[0], irq_line}, 32'h0);
        eng_err = 1'b1; tick(); eng_err = 1'b0;
        repeat (3) tick();
        chk("R8", "error event sticky", 32'(irq_raw[1]), 32'h1);
        wr_clr(5'b10000);
        chk("R10", "level cleared by ack", 32'(irq_raw[4]), 32'h0);
        tick();
        chk("R10", "level sets again", 32'(irq_raw[4]), 32'h1);
        wr_mask(5'b10010);
        chk("R9", "masked status", 32'(irq_stat), 32'b10010);
        chk("R9", "line high", 32'(irq_line), 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule